// File: doc/BRIEF.md
# Audio Source Selection Controller

This block picks which of eight digital audio sources feeds the receiver, and drives the front-panel lamps that show the choice. The sources are three optical inputs (panel positions 1 to 3), a USB bridge (position 4), three coaxial inputs (positions 5 to 7) and a memory-card player (position 8). The panel order differs from the order of the receiver's input multiplexer, so the block converts the selected panel position into a receiver input index. A debounced button pulse steps through the sources. A USB host that appears takes the selection at once. The card source can be chosen only while a card is seated. An optional scan mode moves away from a source that has gone quiet and goes to the next source that reports a signal.

At startup the block senses a jumper-style option switch. It drives the switch pin high for a few cycles and reads it back; a closed switch pulls the pin low. While this probe runs, every lamp is dark and the selection does not move. The lamps use two open-drain pins each: no pin pulled means off, one pin pulled means dim, and both pins pulled means bright. A separate group of sample-rate lamps shows one lamp for the current rate class. That lamp is bright when real audio is present and dim when only a bare carrier is locked.

Top module: `audio_source_selector`

## Requirements
- R1: After reset, `optDrive` is 1 for exactly `PROBE_CYCLES` clock cycles (default 8). During this window every lamp output is 0, `selPanel` stays 0 and button pulses are ignored.
- R2: `optSense` is sampled in the last probe cycle. A value of 0 (switch closed) enables scan mode and a value of 1 disables it, until the next reset.
- R3: `rxInput` gives the receiver index for `selPanel` (zero-based panel index). Panel indices 0,1,2 map to 4,5,6. Index 3 maps to 0. Indices 4,5,6 map to 1,2,3. Index 7 maps to 7.
- R4: A `btnPulse` moves `selPanel` to the next index, wrapping from 7 to 0. When `cardDetect` is 0, index 7 is skipped, so 6 goes to 0.
- R5: A 0-to-1 change of `usbPresent` while running sets `selPanel` to 3 on the next edge. The same applies when `usbPresent` is already 1 in the first running cycle. A steady high level does not force it again.
- R6: When `selPanel` is 7 and `cardDetect` is 0, the next edge sets `selPanel` to 0.
- R7: With scan enabled, if the selected source is not valid, the next edge moves `selPanel` to the first valid index after it, searching upward with wrap. If no source is valid, the selection holds. With scan disabled, a missing signal never moves the selection. Source i is valid when `sigPresent[i]` is 1; index 7 also needs `cardDetect`.
- R8: Input lamp i has pins `inLedA[i]`/`inLedB[i]`, where 1 means the pin pulls low. The selected source has both pins at 1 (bright). Any other valid source has only A at 1 (dim). All others have 0.
- R9: When `lockValid` is 1, `rateLedA` has exactly bit `rateCode` set. When `lockValid` is 0, `rateLedA` is 0. `rateLedB` equals `rateLedA` when `audioPresent` is 1, and is 0 otherwise.
- R10: When several events fall on the same edge, the priority from highest to lowest is: USB rise (R5), card removal (R6), button (R4), scan (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btnPulse | input | 1 | One-cycle pulse per debounced button press |
| usbPresent | input | 1 | USB bridge powered and attached |
| cardDetect | input | 1 | Memory card seated |
| sigPresent | input | 8 | Per-source signal present, indexed by panel index |
| lockValid | input | 1 | Receiver locked to a stream |
| audioPresent | input | 1 | Locked stream carries audio rather than a bare carrier |
| rateCode | input | RATE_W | Sample-rate class code |
| optSense | input | 1 | Read-back of the option switch pin |
| optDrive | output | 1 | Drives the option switch pin high during the probe |
| selPanel | output | 3 | Selected panel index (panel number minus one) |
| rxInput | output | 3 | Receiver input index for the selection |
| inLedA | output | 8 | First pull-low enable of each source lamp |
| inLedB | output | 8 | Second pull-low enable of each source lamp |
| rateLedA | output | 2**RATE_W | First pull-low enable of each rate lamp |
| rateLedB | output | 2**RATE_W | Second pull-low enable of each rate lamp |

## Verification
The selection register moves on the first rising edge that samples an event, so `selPanel`, `rxInput` and the lamp drives reflect a button, USB, card or scan event one clock after the event is presented. The rate lamps and the dim state of a source lamp follow their inputs in the same cycle. The bench drives inputs on the falling edge and compares every output against its reference model shortly after that edge. The model updates only on rising edges, so both the zero-cycle and the one-cycle results are checked in the cycle they are due. Directed checks after each scenario step confirm the probe length, option sensing, priority and scan outcomes.

// File: rtl/audsel_pkg.sv
package audsel_pkg;

  localparam int NUM_SRC  = 8;
  localparam int SEL_W    = 3;
  localparam int HOME_IDX = 0;
  localparam int USB_IDX  = 3;
  localparam int CARD_IDX = 7;

  typedef logic [SEL_W-1:0] selIdx_t;

  // Strobes from control to datapath; at most one is set in a cycle.
  typedef struct packed {
    logic goUsb;
    logic goHome;
    logic step;
    logic hunt;
  } selCmd_t;

  // Panel index to receiver multiplexer index (see R3).
  function automatic selIdx_t panelToRx(input selIdx_t p);
    selIdx_t r;
    if (p < selIdx_t'(USB_IDX))       r = selIdx_t'(p + selIdx_t'(4));
    else if (p == selIdx_t'(USB_IDX)) r = selIdx_t'(0);
    else if (p == selIdx_t'(CARD_IDX)) r = selIdx_t'(CARD_IDX);
    else                              r = selIdx_t'(p - selIdx_t'(3));
    return r;
  endfunction

endpackage

// File: rtl/audsel_ctrl.sv
module audsel_ctrl
  import audsel_pkg::*;
#(
  parameter int PROBE_CYCLES = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    btnPulse,
  input  logic    usbPresent,
  input  logic    cardDetect,
  input  logic    optSense,
  input  logic    selIsCard,
  input  logic    selHasSig,
  output selCmd_t cmd,
  output logic    ready,
  output logic    optDrive
);

  localparam int PCNT_W = (PROBE_CYCLES > 1) ? $clog2(PROBE_CYCLES) : 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PROBE_CYCLES - 1);

  typedef enum logic {ST_PROBE, ST_RUN} ctrlState_t;

  ctrlState_t        state;
  logic [PCNT_W-1:0] probeCnt;
  logic              scanEn;
  logic              usbPrev;
  logic              usbRise;
  logic              cardGone;

  // Startup probe, then run; usbPrev only follows the line while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PROBE;
      probeCnt <= '0;
      scanEn   <= 1'b0;
      usbPrev  <= 1'b0;
    end else begin
      case (state)
        ST_PROBE: begin
          if (probeCnt == PCNT_LAST) begin
            scanEn <= ~optSense;
            state  <= ST_RUN;
          end else begin
            probeCnt <= probeCnt + 1'b1;
          end
        end
        default: usbPrev <= usbPresent;
      endcase
    end
  end

  assign ready    = (state == ST_RUN);
  assign optDrive = (state == ST_PROBE);
  assign usbRise  = ready & usbPresent & ~usbPrev;
  assign cardGone = selIsCard & ~cardDetect;

  // Fixed priority: USB rise, card removal, button, scan.
  always_comb begin
    cmd = '0;
    if (ready) begin
      if (usbRise)                    cmd.goUsb  = 1'b1;
      else if (cardGone)              cmd.goHome = 1'b1;
      else if (btnPulse)              cmd.step   = 1'b1;
      else if (scanEn && !selHasSig)  cmd.hunt   = 1'b1;
    end
  end

endmodule

// File: rtl/audsel_datapath.sv
module audsel_datapath
  import audsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  selCmd_t            cmd,
  input  logic               ready,
  input  logic [NUM_SRC-1:0] sigPresent,
  input  logic               cardDetect,
  output selIdx_t            selIdx,
  output selIdx_t            rxIdx,
  output logic               selIsCard,
  output logic               selHasSig,
  output logic [NUM_SRC-1:0] inLedA,
  output logic [NUM_SRC-1:0] inLedB
);

  logic [NUM_SRC-1:0] validVec;
  selIdx_t            selQ;
  selIdx_t            stepIdx;
  selIdx_t            huntIdx;
  logic               huntFound;

  // A source counts as valid when it reports signal; the card also needs a card.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_valid
    if (i == CARD_IDX) begin : g_card
      assign validVec[i] = sigPresent[i] & cardDetect;
    end else begin : g_plain
      assign validVec[i] = sigPresent[i];
    end
  end

  // Next index for a button step, skipping the card slot when empty.
  always_comb begin
    stepIdx = selIdx_t'(selQ + 1'b1);
    if (stepIdx == selIdx_t'(CARD_IDX) && !cardDetect)
      stepIdx = selIdx_t'(HOME_IDX);
  end

  // First valid source after the current one, searching upward with wrap.
  always_comb begin
    huntIdx   = selQ;
    huntFound = 1'b0;
    for (int k = 1; k < NUM_SRC; k++) begin
      if (!huntFound && validVec[selIdx_t'(int'(selQ) + k)]) begin
        huntIdx   = selIdx_t'(int'(selQ) + k);
        huntFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ <= selIdx_t'(HOME_IDX);
    end else begin
      if (cmd.goUsb)                  selQ <= selIdx_t'(USB_IDX);
      else if (cmd.goHome)            selQ <= selIdx_t'(HOME_IDX);
      else if (cmd.step)              selQ <= stepIdx;
      else if (cmd.hunt && huntFound) selQ <= huntIdx;
    end
  end

  assign selIdx    = selQ;
  assign rxIdx     = panelToRx(selQ);
  assign selIsCard = (selQ == selIdx_t'(CARD_IDX));
  assign selHasSig = validVec[selQ];

  // Two-pin lamp drive: selected bright, other valid sources dim.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_led
    assign inLedA[i] = ready & ((selQ == selIdx_t'(i)) | validVec[i]);
    assign inLedB[i] = ready & (selQ == selIdx_t'(i));
  end

endmodule

// File: rtl/audsel_rate_led.sv
module audsel_rate_led #(
  parameter  int RATE_W   = 2,
  localparam int NUM_RATE = 1 << RATE_W
) (
  input  logic                ready,
  input  logic                lockValid,
  input  logic                audioPresent,
  input  logic [RATE_W-1:0]   rateCode,
  output logic [NUM_RATE-1:0] rateLedA,
  output logic [NUM_RATE-1:0] rateLedB
);

  for (genvar r = 0; r < NUM_RATE; r++) begin : g_rate
    assign rateLedA[r] = ready & lockValid & (rateCode == RATE_W'(r));
    assign rateLedB[r] = rateLedA[r] & audioPresent;
  end

endmodule

// File: rtl/audio_source_selector.sv
module audio_source_selector
  import audsel_pkg::*;
#(
  parameter  int PROBE_CYCLES = 8,
  parameter  int RATE_W       = 2,
  localparam int NUM_RATE     = 1 << RATE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                btnPulse,
  input  logic                usbPresent,
  input  logic                cardDetect,
  input  logic [NUM_SRC-1:0]  sigPresent,
  input  logic                lockValid,
  input  logic                audioPresent,
  input  logic [RATE_W-1:0]   rateCode,
  input  logic                optSense,
  output logic                optDrive,
  output logic [SEL_W-1:0]    selPanel,
  output logic [SEL_W-1:0]    rxInput,
  output logic [NUM_SRC-1:0]  inLedA,
  output logic [NUM_SRC-1:0]  inLedB,
  output logic [NUM_RATE-1:0] rateLedA,
  output logic [NUM_RATE-1:0] rateLedB
);

  selCmd_t cmd;
  logic    ready;
  logic    selIsCard;
  logic    selHasSig;

  audsel_ctrl #(.PROBE_CYCLES(PROBE_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .btnPulse   (btnPulse),
    .usbPresent (usbPresent),
    .cardDetect (cardDetect),
    .optSense   (optSense),
    .selIsCard  (selIsCard),
    .selHasSig  (selHasSig),
    .cmd        (cmd),
    .ready      (ready),
    .optDrive   (optDrive)
  );

  audsel_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .ready      (ready),
    .sigPresent (sigPresent),
    .cardDetect (cardDetect),
    .selIdx     (selPanel),
    .rxIdx      (rxInput),
    .selIsCard  (selIsCard),
    .selHasSig  (selHasSig),
    .inLedA     (inLedA),
    .inLedB     (inLedB)
  );

  audsel_rate_led #(.RATE_W(RATE_W)) u_rate (
    .ready        (ready),
    .lockValid    (lockValid),
    .audioPresent (audioPresent),
    .rateCode     (rateCode),
    .rateLedA     (rateLedA),
    .rateLedB     (rateLedB)
  );

endmodule

// File: rtl/audsel_checker.sv
module audsel_checker #(
  parameter  int RATE_W   = 2,
  localparam int NUM_RATE = 1 << RATE_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                btnPulse,
  input logic                usbPresent,
  input logic                cardDetect,
  input logic [7:0]          sigPresent,
  input logic                optDrive,
  input logic [2:0]          selPanel,
  input logic [7:0]          inLedA,
  input logic [7:0]          inLedB,
  input logic [NUM_RATE-1:0] rateLedA,
  input logic [NUM_RATE-1:0] rateLedB
);

  p_probe_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    optDrive |-> (inLedA == '0 && inLedB == '0 && rateLedA == '0));

  p_probe_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    optDrive |=> $stable(selPanel));

  p_skip_card_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!optDrive && !usbPresent && btnPulse && selPanel == 3'd6 && !cardDetect)
    |=> (selPanel == 3'd0));

  p_usb_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!optDrive && !$past(optDrive) && usbPresent && !$past(usbPresent))
    |=> (selPanel == 3'd3));

  p_card_pulled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!optDrive && selPanel == 3'd7 && !cardDetect && !usbPresent)
    |=> (selPanel == 3'd0));

  p_hold_no_signal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!optDrive && sigPresent == '0 && cardDetect && !usbPresent && !btnPulse)
    |=> $stable(selPanel));

  p_lamp_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((inLedB & ~inLedA) == '0) && ($countones(inLedB) <= 1));

  p_rate_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rateLedA) && ((rateLedB & ~rateLedA) == '0));

endmodule

bind audio_source_selector audsel_checker #(.RATE_W(RATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .btnPulse   (btnPulse),
  .usbPresent (usbPresent),
  .cardDetect (cardDetect),
  .sigPresent (sigPresent),
  .optDrive   (optDrive),
  .selPanel   (selPanel),
  .inLedA     (inLedA),
  .inLedB     (inLedB),
  .rateLedA   (rateLedA),
  .rateLedB   (rateLedB)
);

// File: tb/test_audio_source_selector.sv
module test_audio_source_selector;

  localparam int CLK_PERIOD = 10;
  localparam int PROBE      = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btnPulse = 1'b0;
  logic       usbPresent = 1'b0;
  logic       cardDetect = 1'b0;
  logic [7:0] sigPresent = '0;
  logic       lockValid = 1'b0;
  logic       audioPresent = 1'b0;
  logic [1:0] rateCode = '0;
  logic       optSense = 1'b1;
  logic       optDrive;
  logic [2:0] selPanel;
  logic [2:0] rxInput;
  logic [7:0] inLedA, inLedB;
  logic [3:0] rateLedA, rateLedB;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_source_selector #(.PROBE_CYCLES(PROBE), .RATE_W(2)) i_audio_source_selector (
    .clk(clk), .rst_n(rst_n), .btnPulse(btnPulse), .usbPresent(usbPresent),
    .cardDetect(cardDetect), .sigPresent(sigPresent), .lockValid(lockValid),
    .audioPresent(audioPresent), .rateCode(rateCode), .optSense(optSense),
    .optDrive(optDrive), .selPanel(selPanel), .rxInput(rxInput),
    .inLedA(inLedA), .inLedB(inLedB), .rateLedA(rateLedA), .rateLedB(rateLedB)
  );

  // Behavioural reference model
  int mSel = 0, mCnt = 0;
  bit mProbe = 1, mScan = 0, mUsbPrev = 0;

  function automatic bit srcValid(int i);
    return sigPresent[i] && (i != 7 || cardDetect);
  endfunction

  function automatic int rxOf(int p);
    case (p)
      0: return 4;  1: return 5;  2: return 6;  3: return 0;
      4: return 1;  5: return 2;  6: return 3;  default: return 7;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mSel = 0; mCnt = 0; mProbe = 1; mScan = 0; mUsbPrev = 0;
    end else if (mProbe) begin
      if (mCnt == PROBE - 1) begin mScan = !optSense; mProbe = 0; end
      else mCnt++;
    end else begin
      if (usbPresent && !mUsbPrev) mSel = 3;
      else if (mSel == 7 && !cardDetect) mSel = 0;
      else if (btnPulse) begin
        mSel = (mSel + 1) % 8;
        if (mSel == 7 && !cardDetect) mSel = 0;
      end else if (mScan && !srcValid(mSel)) begin
        for (int k = 1; k < 8; k++) begin
          if (srcValid((mSel + k) % 8)) begin mSel = (mSel + k) % 8; break; end
        end
      end
      mUsbPrev = usbPresent;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, just after each falling edge
  always @(negedge clk) begin
    #1;
    begin
      logic [7:0] eA, eB;
      logic [3:0] rA, rB;
      for (int i = 0; i < 8; i++) begin
        eA[i] = !mProbe && (i == mSel || srcValid(i));
        eB[i] = !mProbe && (i == mSel);
      end
      rA = (!mProbe && lockValid) ? (4'b0001 << rateCode) : 4'b0000;
      rB = audioPresent ? rA : 4'b0000;
      check(optDrive == mProbe, "R1 optDrive", optDrive, mProbe);
      check(selPanel == mSel, "R4 selPanel", selPanel, mSel);
      check(rxInput == rxOf(mSel), "R3 rxInput", rxInput, rxOf(mSel));
      check(inLedA == eA, "R8 inLedA", inLedA, eA);
      check(inLedB == eB, "R8 inLedB", inLedB, eB);
      check(rateLedA == rA, "R9 rateLedA", rateLedA, rA);
      check(rateLedB == rB, "R9 rateLedB", rateLedB, rB);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press();
    @(negedge clk) btnPulse = 1'b1;
    @(negedge clk) btnPulse = 1'b0;
  endtask

  task automatic expSel(input int e, input string tag);
    #2 check(selPanel == e, tag, selPanel, e);
  endtask

  task automatic doReset(input bit sense);
    @(negedge clk);
    rst_n = 1'b0; optSense = sense; usbPresent = 0; cardDetect = 0;
    sigPresent = '0; btnPulse = 0;
    tick(2);
    rst_n = 1'b1;
  endtask

  initial begin
    // Scenario A: switch open, scan disabled
    doReset(1'b1);
    #2 check(optDrive == 1'b1, "R1 probe active", optDrive, 1);
    press();
    expSel(0, "R1 button ignored in probe");
    check(inLedA == 0 && inLedB == 0, "R1 lamps dark in probe", inLedA, 0);
    tick(PROBE);
    #2 check(optDrive == 1'b0, "R1 probe ended", optDrive, 0);
    tick(3);
    expSel(0, "R2 open switch leaves scan off (R7 hold)");
    for (int n = 1; n <= 6; n++) press();
    expSel(6, "R4 six presses");
    press();
    expSel(0, "R4 card slot skipped");
    cardDetect = 1;
    for (int n = 0; n < 7; n++) press();
    expSel(7, "R4 card slot reachable");
    #2 check(rxInput == 7, "R3 card receiver index", rxInput, 7);
    @(negedge clk) cardDetect = 0;
    tick(1);
    expSel(0, "R6 card removed");
    sigPresent = 8'b1010_0101;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk) rateCode = 2'(c); lockValid = 1; audioPresent = c[0];
      #2 check(rateLedA == (4'b1 << c), "R9 rate one-hot", rateLedA, 4'b1 << c);
    end
    @(negedge clk) lockValid = 0;
    #2 check(rateLedA == 0, "R9 no lock dark", rateLedA, 0);
    @(negedge clk) usbPresent = 1;
    tick(1);
    expSel(3, "R5 usb rise");
    #2 check(rxInput == 0, "R3 usb receiver index", rxInput, 0);
    press();
    expSel(4, "R5 steady usb not re-forced");
    @(negedge clk) usbPresent = 0;
    @(negedge clk) usbPresent = 1; btnPulse = 1;
    @(negedge clk) btnPulse = 0;
    expSel(3, "R10 usb beats button");
    cardDetect = 1;
    for (int n = 0; n < 4; n++) press();
    expSel(7, "R4 to card again");
    @(negedge clk) cardDetect = 0; btnPulse = 1;
    @(negedge clk) btnPulse = 0;
    expSel(0, "R10 card removal beats button");

    // Scenario B: switch closed, scan enabled
    doReset(1'b0);
    tick(PROBE + 2);
    expSel(0, "R7 nothing valid holds");
    @(negedge clk) sigPresent = 8'h20;
    tick(1);
    expSel(5, "R2 closed switch enables scan (R7 hunt)");
    @(negedge clk) sigPresent = 8'h02;
    tick(1);
    expSel(1, "R7 hunt wraps");
    @(negedge clk) sigPresent = 8'h80;
    tick(2);
    expSel(1, "R7 card signal without card ignored");
    @(negedge clk) cardDetect = 1;
    tick(1);
    expSel(7, "R7 hunt reaches card");
    @(negedge clk) cardDetect = 0;
    tick(1);
    expSel(0, "R6 card removed under scan");
    @(negedge clk) sigPresent = 8'h00; usbPresent = 1;
    tick(2);
    expSel(3, "R5 usb under scan holds");
    tick(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule